// File: doc/BRIEF.md
# Rotated-Offset Call-Target Membership Checker

This block decides whether a 64-bit table pointer is a permitted target for one call-site type. For each request the caller supplies the pointer together with that type's parameters: a base address, an alignment shift, an inclusive upper bound on the index, a check mode, an inline vector and a byte mask. The block subtracts the base from the pointer and rotates the 64-bit difference right by the shift. A pointer below the base, past the end, or off the required alignment then ends up as an index above the bound. A single unsigned compare rejects all three cases. The surviving index selects one membership bit, either from the inline vector or from a byte of a shared array.

There are four modes: inline vector, shared byte array, exact address and aligned-range-only. The byte array sits outside the block behind a synchronous read port with one cycle of latency. Several types can share the same bytes, each type using its own bit position. Requests use a valid/ready handshake and results come back as a registered valid/pass pair. The controller has two states. In `S_IDLE` a request is accepted whenever valid is high. The transition `S_IDLE -> S_FETCH` is taken when a byte-array request is accepted. The transition `S_FETCH -> S_IDLE` is always taken one cycle later, when the byte has returned and the verdict is registered. All other modes remain in `S_IDLE`.

Top module: `vmc_checker`

## Requirements
- R1: The index is ror64(ptr - base, shift), with shift taken from the 6-bit field. In every mode except exact address, a request whose index is unsigned-greater than bound fails. This covers pointers below base and pointers past the end.
- R2: A pointer whose difference from base has any nonzero bit below bit position shift fails in every rotating mode, because those bits rotate to the top of the index.
- R3: Inline mode (mode code 0): pass equals (index <= bound) AND vec[index], where the low 6 index bits select the bit. A 32-bit constant is supplied zero-extended.
- R4: Byte-array mode (mode code 1): the block asserts mem_rd_en for one cycle with mem_rd_addr equal to the low address bits of the index. Pass equals (index <= bound) AND ((byte AND mask) != 0). The response appears two cycles after acceptance.
- R5: In byte-array mode, an index above bound issues no read, and the request fails.
- R6: Exact-address mode (mode code 2): pass equals (ptr == base), and shift, bound, vec and mask have no effect.
- R7: Aligned-range mode (mode code 3): pass equals (index <= bound), with no bit test.
- R8: Modes 0, 2 and 3 answer with rsp_valid high for exactly one cycle, one cycle after acceptance. A new request may be accepted in the same cycle that a response is shown.
- R9: req_ready is low for the cycle in which a byte lookup is in flight, and no request is accepted during that cycle.
- R10: During reset, req_ready is high and both rsp_valid and mem_rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_mode | input | 2 | 0 inline, 1 byte array, 2 exact address, 3 aligned range |
| req_ptr | input | 64 | Table pointer under test |
| req_base | input | 64 | Type base address (first set position) |
| req_shift | input | 6 | Rotate amount, log2 of alignment |
| req_bound | input | 64 | Last valid rotated index |
| req_vec | input | 64 | Inline membership vector |
| req_mask | input | 8 | One-hot bit selecting the type inside each shared byte |
| mem_rd_en | output | 1 | Byte-array read strobe |
| mem_rd_addr | output | 16 | Byte-array read address |
| mem_rd_data | input | 8 | Byte returned one cycle after the strobe |
| rsp_valid | output | 1 | Verdict present |
| rsp_pass | output | 1 | 1 when the pointer is a permitted target |

## Verification
Two functions can coincide in one cycle: a verdict is shown on the response port while the next request is accepted. This happens after every single-cycle mode and also on the cycle the controller returns from `S_FETCH`. The bench provokes it by issuing requests back to back, each one driven on the cycle after the previous acceptance, and by mixing byte-array lookups with inline and exact requests. A behavioural reference holds a queue of expected verdicts, each with the cycle it is due in. Every cycle it checks that exactly the due verdict appears and that no extra response appears while the next request is being taken.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

    typedef enum logic [1:0] {
        CHK_INLINE  = 2'd0,
        CHK_BYTES   = 2'd1,
        CHK_EXACT   = 2'd2,
        CHK_ALIGNED = 2'd3
    } chk_mode_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_FETCH = 1'b1
    } vmc_state_e;

endpackage

// File: rtl/vmc_index.sv
module vmc_index #(
    parameter int PW = 64,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ptr,
    input  logic [PW-1:0] base,
    input  logic [SW-1:0] shift,
    input  logic [PW-1:0] bound,
    output logic [PW-1:0] idx,
    output logic          in_range
);
    localparam int DW = 2 * PW;

    logic [PW-1:0] diff;
    logic [DW-1:0] doubled;

    always_comb begin
        diff     = ptr - base;
        doubled  = {diff, diff} >> shift;
        idx      = doubled[PW-1:0];
        in_range = (idx <= bound);
    end

    // R2: with a modest bound and shift, an accepted index means aligned difference
    p_aligned_when_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && bound[PW-1:PW-8] == 8'd0 && shift <= SW'(8))
            |-> ((diff & ((PW'(1) << shift) - PW'(1))) == '0));

endmodule

// File: rtl/vmc_inline_pick.sv
module vmc_inline_pick #(
    parameter int VW = 64
) (
    input  logic [VW-1:0]         vec,
    input  logic [$clog2(VW)-1:0] sel,
    output logic                  bit_out
);
    generate
        if (VW == 1) begin : g_single
            assign bit_out = vec[0];
        end else begin : g_multi
            assign bit_out = vec[sel];
        end
    endgenerate
endmodule

// File: rtl/vmc_checker.sv
module vmc_checker
    import vmc_pkg::*;
#(
    parameter int PW = 64,
    parameter int SW = 6,
    parameter int VW = 64,
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_mode,
    input  logic [PW-1:0] req_ptr,
    input  logic [PW-1:0] req_base,
    input  logic [SW-1:0] req_shift,
    input  logic [PW-1:0] req_bound,
    input  logic [VW-1:0] req_vec,
    input  logic [BW-1:0] req_mask,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [BW-1:0] mem_rd_data,
    output logic          rsp_valid,
    output logic          rsp_pass
);
    localparam int VSW = (VW > 1) ? $clog2(VW) : 1;

    vmc_state_e    state, state_nx;
    chk_mode_e     mode;
    logic [PW-1:0] idx;
    logic          in_range;
    logic          vbit;
    logic          accept;
    logic          verdict_now;
    logic [BW-1:0] mask_q;
    logic          hit_q;

    vmc_index #(.PW(PW), .SW(SW)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr      (req_ptr),
        .base     (req_base),
        .shift    (req_shift),
        .bound    (req_bound),
        .idx      (idx),
        .in_range (in_range)
    );

    vmc_inline_pick #(.VW(VW)) u_pick (
        .vec     (req_vec),
        .sel     (idx[VSW-1:0]),
        .bit_out (vbit)
    );

    assign mode        = chk_mode_e'(req_mode);
    assign req_ready   = (state == S_IDLE);
    assign accept      = req_valid && req_ready;
    assign mem_rd_en   = accept && (mode == CHK_BYTES) && in_range;
    assign mem_rd_addr = idx[AW-1:0];

    always_comb begin
        unique case (mode)
            CHK_INLINE:  verdict_now = in_range && vbit;
            CHK_EXACT:   verdict_now = (req_ptr == req_base);
            CHK_ALIGNED: verdict_now = in_range;
            CHK_BYTES:   verdict_now = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept && mode == CHK_BYTES) state_nx = S_FETCH;
            S_FETCH: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pass  <= 1'b0;
            mask_q    <= '0;
            hit_q     <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (accept && mode != CHK_BYTES) begin
                        rsp_valid <= 1'b1;
                        rsp_pass  <= verdict_now;
                    end else if (accept) begin
                        mask_q <= req_mask;
                        hit_q  <= in_range;
                    end
                end
                S_FETCH: begin
                    rsp_valid <= 1'b1;
                    rsp_pass  <= hit_q && ((mem_rd_data & mask_q) != '0);
                end
            endcase
        end
    end

    // R8: single-cycle modes answer on the next cycle
    p_quick_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode != CHK_BYTES) |=> rsp_valid);

    // R4: byte lookups answer exactly two cycles after acceptance
    p_byte_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == CHK_BYTES) |=> (!rsp_valid ##1 rsp_valid));

    // R5: a read is only issued for an index within the bound
    p_read_in_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (idx <= req_bound));

    // R9: the handshake is closed while the byte is returning
    p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !req_ready);

    // R6: exact mode verdict depends only on pointer and base
    p_exact_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == CHK_EXACT) |=> (rsp_pass == ($past(req_ptr) == $past(req_base))));

endmodule

// File: tb/vmc_checker_bench.sv
module vmc_checker_bench;

    typedef struct {
        int    due;
        bit    pass;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_mode = 2'd0;
    logic [63:0] req_ptr = '0;
    logic [63:0] req_base = '0;
    logic [5:0]  req_shift = '0;
    logic [63:0] req_bound = '0;
    logic [63:0] req_vec = '0;
    logic [7:0]  req_mask = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_pass;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #5 clk = ~clk;

    vmc_checker u_vmc_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_ptr(req_ptr), .req_base(req_base),
        .req_shift(req_shift), .req_bound(req_bound), .req_vec(req_vec),
        .req_mask(req_mask), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass)
    );

    function automatic logic [7:0] arr_byte(input logic [15:0] a);
        case (a)
            16'd2:   return 8'd1;
            16'd6:   return 8'd3;
            16'd11:  return 8'd5;
            default: return 8'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) mem_rd_data <= arr_byte(mem_rd_addr);
    end

    function automatic logic [63:0] rot_one_by_one(input logic [63:0] x, input int n);
        logic [63:0] r = x;
        for (int i = 0; i < n; i++) r = {r[0], r[63:1]};
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // reference comparison every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
                check(rsp_valid === 1'b1 && rsp_pass === expq[0].pass, expq[0].tag,
                      "verdict", {62'd0, rsp_valid, rsp_pass}, {62'd0, 1'b1, expq[0].pass});
                void'(expq.pop_front());
            end else if (rsp_valid !== 1'b0) begin
                check(1'b0, "R8", "unexpected response", 64'(rsp_valid), 64'd0);
            end
        end
    end

    initial begin
        #200000;
        check(1'b0, "WATCHDOG", "run hung", 64'd0, 64'd1);
        finish_run();
    end

    // called at a negedge; leaves at the negedge after acceptance
    task automatic issue(input string tag, input logic [1:0] m, input logic [63:0] p,
                         input logic [63:0] b, input logic [5:0] s, input logic [63:0] bnd,
                         input logic [63:0] v, input logic [7:0] mk);
        logic [63:0] ix;
        bit inr, pass;
        exp_t e;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_ptr = p; req_base = b;
        req_shift = s; req_bound = bnd; req_vec = v; req_mask = mk;
        ix  = rot_one_by_one(p - b, int'(s));
        inr = (ix <= bnd);
        case (m)
            2'd0:    pass = inr && v[ix[5:0]];
            2'd1:    pass = inr && ((arr_byte(ix[15:0]) & mk) != 8'd0);
            2'd2:    pass = (p == b);
            default: pass = inr;
        endcase
        #1;
        if (m == 2'd1) begin
            check(mem_rd_en === inr, inr ? "R4" : "R5", "read strobe", 64'(mem_rd_en), 64'(inr));
            if (inr) check(mem_rd_addr === ix[15:0], "R4", "read address",
                           64'(mem_rd_addr), 64'(ix[15:0]));
        end
        e.due = cyc + ((m == 2'd1) ? 2 : 1);
        e.pass = pass;
        e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 2'd1) check(req_ready === 1'b0, "R9", "ready during fetch", 64'(req_ready), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(req_ready === 1'b1, "R10", "ready in reset", 64'(req_ready), 64'd1);
        check(rsp_valid === 1'b0, "R10", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check(mem_rd_en === 1'b0, "R10", "rd_en in reset", 64'(mem_rd_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: inline 0x9, bound 3, 8-byte entries, back to back
        for (int i = 0; i < 4; i++)
            issue("R3", 2'd0, 64'h1000 + 64'(8 * i), 64'h1000, 6'd3, 64'd3, 64'h9, 8'h0);
        // R1: past the end and below base
        issue("R1", 2'd0, 64'h1020, 64'h1000, 6'd3, 64'd3, 64'h9, 8'h0);
        issue("R1", 2'd0, 64'h0FF8, 64'h1000, 6'd3, 64'd3, 64'hF, 8'h0);
        // R2: misaligned inside the range
        issue("R2", 2'd0, 64'h1004, 64'h1000, 6'd3, 64'd3, 64'hF, 8'h0);
        // R3: 64-bit constant, bound 0x2A
        issue("R3", 2'd0, 64'h4000 + 64'(8 * 42), 64'h4000, 6'd3, 64'h2A, 64'h40000000009, 8'h0);
        issue("R3", 2'd0, 64'h4000 + 64'(8 * 41), 64'h4000, 6'd3, 64'h2A, 64'h40000000009, 8'h0);

        // R4: shared bytes, three types on bits 0..2
        issue("R4", 2'd1, 64'h2000 + 64'(8 * 6),  64'h2000, 6'd3, 64'd13, 64'h0, 8'h1);
        issue("R3", 2'd0, 64'h1018, 64'h1000, 6'd3, 64'd3, 64'h9, 8'h0);
        issue("R4", 2'd1, 64'h2000 + 64'(8 * 11), 64'h2000, 6'd3, 64'd13, 64'h0, 8'h1);
        issue("R4", 2'd1, 64'h2000 + 64'(8 * 2),  64'h2000, 6'd3, 64'd13, 64'h0, 8'h1);
        issue("R4", 2'd1, 64'h2000 + 64'(8 * 6),  64'h2000, 6'd3, 64'd13, 64'h0, 8'h2);
        issue("R4", 2'd1, 64'h2000 + 64'(8 * 11), 64'h2000, 6'd3, 64'd13, 64'h0, 8'h2);
        issue("R4", 2'd1, 64'h2000 + 64'(8 * 11), 64'h2000, 6'd3, 64'd13, 64'h0, 8'h4);
        issue("R4", 2'd1, 64'h2000 + 64'(8 * 6),  64'h2000, 6'd3, 64'd13, 64'h0, 8'h4);
        // R5: out of bound and misaligned byte lookups
        issue("R5", 2'd1, 64'h2000 + 64'(8 * 14), 64'h2000, 6'd3, 64'd13, 64'h0, 8'h7);
        issue("R5", 2'd1, 64'h2000 + 64'(8 * 6) + 64'd2, 64'h2000, 6'd3, 64'd13, 64'h0, 8'h7);

        // R7: 32-byte alignment, all-ones
        issue("R7", 2'd3, 64'h40, 64'h0, 6'd5, 64'd3, 64'h0, 8'h0);
        issue("R7", 2'd3, 64'h48, 64'h0, 6'd5, 64'd3, 64'h0, 8'h0);
        issue("R7", 2'd3, 64'h80, 64'h0, 6'd5, 64'd3, 64'h0, 8'h0);

        // R6: exact address, other fields meaningless
        issue("R6", 2'd2, 64'h5000, 64'h5000, 6'd17, 64'd0, 64'h0, 8'h0);
        issue("R6", 2'd2, 64'h5008, 64'h5000, 6'd3, 64'hFFFF, 64'hFFFF, 8'hFF);
        issue("R8", 2'd1, 64'h2030, 64'h2000, 6'd3, 64'd13, 64'h0, 8'h1);
        issue("R8", 2'd2, 64'h7000, 64'h7000, 6'd0, 64'd0, 64'h0, 8'h0);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R8", "pending verdicts", 64'(expq.size()), 64'd0);
        finish_run();
    end

endmodule